// File: doc/BRIEF.md
# I2C Bit Timing Generator

This block produces the SCL waveform and the phase ticks that an I2C master engine uses for every bus event. The engine asks for one of three operations: a condition that opens a transfer, a single bit slot, or a condition that closes it. The generator then counts system clock cycles through the programmed low, high and setup intervals. It drives SCL and tells the engine when SDA may change and when SDA should be sampled. During the opening and closing conditions it also owns SDA and states the level to drive.

Four counts, all in system clock cycles, set the timing: the whole SCL period, the SCL low time, a setup count used both for condition setup and for hold after a START, and the data setup lead before SCL rises. The high time is the period less the low time. A low time of about five ninths of the period and a data lead of about one sixteenth suit both standard and fast bus rates. The counts are taken into internal registers only when a START is accepted on a free bus. A transfer already running therefore never sees a timing change partway through.

After a START or a bit slot, the generator leaves SCL held low and the bus owned. After a STOP, SCL and SDA are released and the bus is free.

Top module: `i2c_bit_timer`

## Requirements
- R1: In reset, and on the cycle after it, scl_o is 1 and busy, done, bus_held, sda_own, sda_lvl, chg_tick and smp_tick are all 0.
- R2: A bit slot accepted on an owned bus holds SCL low for L cycles, then high for H cycles, then returns SCL low with done high for one cycle. L is the captured low count (0 read as 1). H is period minus L, or 1 if the period does not exceed L. bus_held stays 1 throughout.
- R3: chg_tick pulses exactly once per low phase, only while SCL is low. It falls on low-phase cycle L-D, counting from 0, where D is the data setup count (0 read as 1). It falls on cycle 0 when D is L or more.
- R4: smp_tick pulses exactly once per bit slot, on high-phase cycle H/2 (rounded down, counting from 0), and only while SCL is high.
- R5: A START on a free bus keeps SCL high with SDA owned at level 1 for S cycles, then owned at level 0 for S cycles, then drives SCL low and sets bus_held. S is the setup count (0 read as 1).
- R6: A START on an owned bus (a repeated START) first runs a low phase of L cycles with SDA owned at level 1, then the same sequence as R5.
- R7: A STOP on an owned bus runs a low phase of L cycles with SDA owned at level 0, then S cycles of SCL high with SDA still at 0. After that SCL and SDA are released and bus_held clears.
- R8: A bit or STOP request on a free bus is ignored: the outputs stay at the free idle levels.
- R9: The timing inputs are captured only when a START is accepted on a free bus. Changes at any other time have no effect on slots or conditions until the next such START.
- R10: Requests made while busy are ignored. When several requests arrive in the same idle cycle, START wins over STOP, and STOP wins over a bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Request a START or repeated START |
| cmd_stop | input | 1 | Request a STOP |
| cmd_bit | input | 1 | Request one bit slot |
| cfg_period | input | CNT_W | Full SCL period in clocks |
| cfg_low | input | CNT_W | SCL low time in clocks |
| cfg_setup | input | CNT_W | Condition setup and START hold in clocks |
| cfg_dsetup | input | CNT_W | SDA lead before SCL rises in clocks |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_own | output | 1 | Generator owns SDA during a condition |
| sda_lvl | output | 1 | SDA level to drive while sda_own is 1 |
| chg_tick | output | 1 | SDA may change in this cycle |
| smp_tick | output | 1 | Sample SDA in this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| bus_held | output | 1 | SCL is held low and the bus is owned |

## Verification
A sweep covers every period from 2 to 9, every low count from 0 up to one past the period, data setup counts 0 to 3, and setup counts 0 to 2. Each configuration runs START, bit, repeated START, bit and STOP, and every output is compared on every cycle. Zero counts, a low count at or above the period, and a data lead at or above the low time show whether the clamps and the tick placement are right. Separate runs issue bit and STOP on a free bus, issue a START in the middle of a slot, issue simultaneous requests, and change the timing inputs mid-transfer. These runs show whether ignored requests, priority and capture gating behave as required.

// File: rtl/i2c_tmg_pkg.sv
// Shared types for the I2C bit timing generator.
package i2c_tmg_pkg;

    // Sequencer phases; each phase except IDLE lasts a counted number of clocks.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOW    = 3'd1,
        PH_HIGH   = 3'd2,
        PH_SUHI   = 3'd3,
        PH_HOLD   = 3'd4,
        PH_STOPHI = 3'd5
    } phase_e;

    // Operation currently being sequenced.
    typedef enum logic [1:0] {
        OP_BIT   = 2'd0,
        OP_START = 2'd1,
        OP_STOP  = 2'd2
    } op_e;

endpackage

// File: rtl/i2c_tmg_cfg.sv
// Timing capture stage.
// Derives clamped phase lengths and tick positions from the raw counts and
// registers them when load is high. Assumes load is asserted only when a
// START is accepted on a free bus. Zero counts are read as one.
module i2c_tmg_cfg #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] raw_period,
    input  logic [CNT_W-1:0] raw_low,
    input  logic [CNT_W-1:0] raw_setup,
    input  logic [CNT_W-1:0] raw_dsetup,
    output logic [CNT_W-1:0] len_low,
    output logic [CNT_W-1:0] len_high,
    output logic [CNT_W-1:0] len_setup,
    output logic [CNT_W-1:0] idx_chg,
    output logic [CNT_W-1:0] idx_smp
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] low_c, high_c, setup_c, dset_c, chg_c, smp_c;

    // Clamp the raw counts and derive the tick positions.
    always_comb begin
        low_c   = (raw_low == '0) ? ONE : raw_low;
        high_c  = (raw_period > low_c) ? (raw_period - low_c) : ONE;
        setup_c = (raw_setup == '0) ? ONE : raw_setup;
        dset_c  = (raw_dsetup == '0) ? ONE : raw_dsetup;
        chg_c   = (dset_c >= low_c) ? '0 : (low_c - dset_c);
        smp_c   = high_c >> 1;
    end

    // Hold the derived values; update only on a capture request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_low   <= ONE;
            len_high  <= ONE;
            len_setup <= ONE;
            idx_chg   <= '0;
            idx_smp   <= '0;
        end else if (load) begin
            len_low   <= low_c;
            len_high  <= high_c;
            len_setup <= setup_c;
            idx_chg   <= chg_c;
            idx_smp   <= smp_c;
        end
    end

    AST_CHG_INSIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        idx_chg < len_low); // R3
    AST_SMP_INSIDE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        idx_smp < len_high); // R4

endmodule

// File: rtl/i2c_tmg_cnt.sv
// Phase cycle counter.
// Counts clocks since the current phase began; clear restarts it at zero.
// Assumes phase lengths fit in CNT_W bits so the count never wraps.
module i2c_tmg_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    // Restart on clear, otherwise advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/i2c_tmg_seq.sv
// Condition and bit-slot sequencer.
// Walks the phases of START, repeated START, bit slot and STOP using the
// phase counter. Also decodes the SCL, SDA ownership and tick outputs.
// Assumes the captured lengths are at least one.
module i2c_tmg_seq
    import i2c_tmg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic             req_stop,
    input  logic             req_bit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] len_low,
    input  logic [CNT_W-1:0] len_high,
    input  logic [CNT_W-1:0] len_setup,
    input  logic [CNT_W-1:0] idx_chg,
    input  logic [CNT_W-1:0] idx_smp,
    output logic             cnt_clr,
    output logic             cfg_load,
    output logic             scl_o,
    output logic             sda_own,
    output logic             sda_lvl,
    output logic             chg_tick,
    output logic             smp_tick,
    output logic             busy,
    output logic             done,
    output logic             bus_held
);
    phase_e           phase_q, phase_d;
    op_e              op_q, op_d;
    logic             held_q, held_d;
    logic             done_q, done_d;
    logic [CNT_W-1:0] cur_len;
    logic             last;

    // Pick the length of the phase in progress.
    always_comb begin
        unique case (phase_q)
            PH_LOW:  cur_len = len_low;
            PH_HIGH: cur_len = len_high;
            PH_SUHI, PH_HOLD, PH_STOPHI: cur_len = len_setup;
            default: cur_len = CNT_W'(1);
        endcase
        last = (cnt == cur_len - CNT_W'(1));
    end

    // Next-phase decision and request arbitration.
    always_comb begin
        phase_d  = phase_q;
        op_d     = op_q;
        held_d   = held_q;
        done_d   = 1'b0;
        cfg_load = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_start) begin
                    op_d = OP_START;
                    if (!held_q) begin
                        cfg_load = 1'b1;
                        phase_d  = PH_SUHI;
                    end else begin
                        phase_d  = PH_LOW;
                    end
                end else if (req_stop && held_q) begin
                    op_d    = OP_STOP;
                    phase_d = PH_LOW;
                end else if (req_bit && held_q) begin
                    op_d    = OP_BIT;
                    phase_d = PH_LOW;
                end
            end
            PH_LOW: begin
                if (last) begin
                    unique case (op_q)
                        OP_START: phase_d = PH_SUHI;
                        OP_STOP:  phase_d = PH_STOPHI;
                        default:  phase_d = PH_HIGH;
                    endcase
                end
            end
            PH_HIGH: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            PH_SUHI: begin
                if (last) phase_d = PH_HOLD;
            end
            PH_HOLD: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    held_d  = 1'b1;
                    done_d  = 1'b1;
                end
            end
            PH_STOPHI: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    held_d  = 1'b0;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
        cnt_clr = (phase_d != phase_q) || (phase_q == PH_IDLE);
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_BIT;
            held_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            op_q    <= op_d;
            held_q  <= held_d;
            done_q  <= done_d;
        end
    end

    // Output decode from the registered phase and count.
    always_comb begin
        scl_o    = (phase_q == PH_HIGH) || (phase_q == PH_SUHI) ||
                   (phase_q == PH_HOLD) || (phase_q == PH_STOPHI) ||
                   ((phase_q == PH_IDLE) && !held_q);
        sda_own  = ((phase_q == PH_LOW) && (op_q != OP_BIT)) ||
                   (phase_q == PH_SUHI) || (phase_q == PH_HOLD) ||
                   (phase_q == PH_STOPHI);
        sda_lvl  = ((phase_q == PH_LOW) && (op_q == OP_START)) ||
                   (phase_q == PH_SUHI);
        chg_tick = (phase_q == PH_LOW) && (cnt == idx_chg);
        smp_tick = (phase_q == PH_HIGH) && (cnt == idx_smp);
        busy     = (phase_q != PH_IDLE);
        done     = done_q;
        bus_held = held_q;
    end

    AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < cur_len)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BIT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |-> bus_held); // R8
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bus_held) |-> (scl_o && !sda_own)); // R7

endmodule

// File: rtl/i2c_bit_timer.sv
// I2C bit timing generator, top level.
// Joins the timing capture stage, the phase counter and the sequencer.
// Assumes timing inputs are steady when a START is requested on a free bus.
module i2c_bit_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_bit,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_dsetup,
    output logic             scl_o,
    output logic             sda_own,
    output logic             sda_lvl,
    output logic             chg_tick,
    output logic             smp_tick,
    output logic             busy,
    output logic             done,
    output logic             bus_held
);
    logic             cnt_clr, cfg_load;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_low, len_high, len_setup, idx_chg, idx_smp;

    i2c_tmg_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .raw_period (cfg_period),
        .raw_low    (cfg_low),
        .raw_setup  (cfg_setup),
        .raw_dsetup (cfg_dsetup),
        .len_low    (len_low),
        .len_high   (len_high),
        .len_setup  (len_setup),
        .idx_chg    (idx_chg),
        .idx_smp    (idx_smp)
    );

    i2c_tmg_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clr),
        .cnt   (cnt)
    );

    i2c_tmg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (cmd_start),
        .req_stop  (cmd_stop),
        .req_bit   (cmd_bit),
        .cnt       (cnt),
        .len_low   (len_low),
        .len_high  (len_high),
        .len_setup (len_setup),
        .idx_chg   (idx_chg),
        .idx_smp   (idx_smp),
        .cnt_clr   (cnt_clr),
        .cfg_load  (cfg_load),
        .scl_o     (scl_o),
        .sda_own   (sda_own),
        .sda_lvl   (sda_lvl),
        .chg_tick  (chg_tick),
        .smp_tick  (smp_tick),
        .busy      (busy),
        .done      (done),
        .bus_held  (bus_held)
    );

    AST_CHG_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        chg_tick |-> !scl_o); // R3
    AST_SMP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> scl_o); // R4
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_held |=> ($stable(len_low) && $stable(len_high) && $stable(len_setup))); // R9
    AST_TICKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_tick && smp_tick)); // R3

endmodule

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_bit = 1'b0;
    logic [W-1:0] cfg_period = '0, cfg_low = '0, cfg_setup = '0, cfg_dsetup = '0;
    logic scl_o, sda_own, sda_lvl, chg_tick, smp_tick, busy, done, bus_held;

    int n_cmp = 0;
    int n_bad = 0;
    int cL = 1, cH = 1, cS = 1, cI = 0, cM = 0;

    always #4 clk = ~clk;

    i2c_bit_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_bit(cmd_bit),
        .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_setup(cfg_setup), .cfg_dsetup(cfg_dsetup),
        .scl_o(scl_o), .sda_own(sda_own), .sda_lvl(sda_lvl),
        .chg_tick(chg_tick), .smp_tick(smp_tick),
        .busy(busy), .done(done), .bus_held(bus_held)
    );

    wire [7:0] obs = {scl_o, sda_own, sda_lvl, chg_tick, smp_tick, busy, done, bus_held};

    task automatic check(input logic [7:0] exp, input string req);
        n_cmp++;
        if (obs !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, obs, exp);
        end
    endtask

    // Capture the timing the requirements say a START on a free bus takes.
    task automatic capture();
        int p = int'(cfg_period), d;
        cL = (cfg_low == 0) ? 1 : int'(cfg_low);
        cH = (p > cL) ? p - cL : 1;
        cS = (cfg_setup == 0) ? 1 : int'(cfg_setup);
        d  = (cfg_dsetup == 0) ? 1 : int'(cfg_dsetup);
        cI = (d >= cL) ? 0 : cL - d;
        cM = cH / 2;
    endtask

    // Drive requests for one cycle; return at the negedge of cycle 0.
    task automatic issue(input bit s, input bit p, input bit b);
        cmd_start = s; cmd_stop = p; cmd_bit = b;
        @(posedge clk);
        @(negedge clk);
        cmd_start = 0; cmd_stop = 0; cmd_bit = 0;
    endtask

    // Expected output word k cycles into an operation.
    // op 0 = bit, 1 = START on free bus, 2 = repeated START, 3 = STOP.
    function automatic logic [7:0] expect_at(input int op, input int k);
        logic c = (k == cI);
        case (op)
            0: begin
                if (k < cL)            return {3'b000, c, 1'b0, 3'b101};
                else if (k < cL + cH)  return {4'b1000, (k - cL) == cM, 3'b101};
                else                   return 8'b00000011;
            end
            1: begin
                if (k < cS)            return 8'b11100100;
                else if (k < 2*cS)     return 8'b11000100;
                else                   return 8'b00000011;
            end
            2: begin
                if (k < cL)            return {3'b011, c, 4'b0101};
                else if (k < cL + cS)  return 8'b11100101;
                else if (k < cL + 2*cS) return 8'b11000101;
                else                   return 8'b00000011;
            end
            default: begin
                if (k < cL)            return {3'b010, c, 4'b0101};
                else if (k < cL + cS)  return 8'b11000101;
                else                   return 8'b10000010;
            end
        endcase
    endfunction

    function automatic int op_len(input int op);
        case (op)
            0: return cL + cH;
            1: return 2*cS;
            2: return cL + 2*cS;
            default: return cL + cS;
        endcase
    endfunction

    // Follow an operation already issued; optional START poke at cycle poke_k.
    task automatic follow(input int op, input string req, input int poke_k);
        for (int k = 0; k <= op_len(op); k++) begin
            check(expect_at(op, k), req);
            if (k == poke_k) cmd_start = 1;
            @(negedge clk);
            cmd_start = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, during and right after reset
        repeat (3) @(negedge clk);
        check(8'b10000000, "R1");
        rst_n = 1;
        @(negedge clk);
        check(8'b10000000, "R1");

        // R8: bit and STOP on a free bus are ignored
        issue(0, 0, 1);
        for (int k = 0; k < 3; k++) begin check(8'b10000000, "R8"); @(negedge clk); end
        issue(0, 1, 0);
        for (int k = 0; k < 3; k++) begin check(8'b10000000, "R8"); @(negedge clk); end

        // Sweep: R2 R3 R4 R5 R6 R7 over small configurations
        for (int p = 2; p <= 9; p++) begin
            for (int l = 0; l <= p + 1; l++) begin
                for (int d = 0; d <= 3; d++) begin
                    cfg_period = W'(p); cfg_low = W'(l);
                    cfg_dsetup = W'(d); cfg_setup = W'((p + l) % 3);
                    capture();
                    issue(1, 0, 0); follow(1, "R5", -1);
                    issue(0, 0, 1); follow(0, "R2/R3/R4", -1);
                    issue(1, 0, 0); follow(2, "R6", -1);
                    issue(0, 0, 1); follow(0, "R2/R3/R4", -1);
                    issue(0, 1, 0); follow(3, "R7", -1);
                end
            end
        end

        // R9: changes after capture do not affect the owned transfer
        cfg_period = 10; cfg_low = 6; cfg_setup = 2; cfg_dsetup = 2;
        capture();
        issue(1, 0, 0); follow(1, "R9", -1);
        cfg_period = 5; cfg_low = 2; cfg_setup = 1; cfg_dsetup = 1;
        issue(0, 0, 1); follow(0, "R9", -1);
        issue(1, 0, 0); follow(2, "R9", -1);
        issue(0, 1, 0); follow(3, "R9", -1);
        capture();
        issue(1, 0, 0); follow(1, "R9", -1);
        issue(0, 0, 1); follow(0, "R9", -1);

        // R10: a START poked mid-slot is ignored
        issue(0, 0, 1); follow(0, "R10", 1);
        // R10: STOP wins over bit on an owned bus
        issue(0, 1, 1); follow(3, "R10", -1);
        // R10: START wins over STOP and bit on a free bus
        issue(1, 1, 1); follow(1, "R10", -1);
        issue(0, 1, 0); follow(3, "R10", -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule